// File: doc/BRIEF.md
# Chirp-Modem Diagonal Interleaver

This block sits between the block coder and the chirp generator of a chirp spread spectrum transmitter. It takes coded words one at a time over a valid/ready stream and collects them into an interleaver block. It then spreads the bits of that block diagonally across output words. Each output word passes through an inverse Gray step, and the result leaves as a symbol number for the modulator, one per handshake.

A packet may open with a header block. The header block always uses full 8-bit codewords and only `sf-2` rows, so each header symbol carries fewer bits. Each header symbol is shifted left by two so that it lands on a coarser grid of the symbol space. All later blocks use `sf` rows of `cr+4`-bit codewords.

The spreading factor, coding rate and header flag are captured once when a packet begins. They stay fixed until the packet's final symbol has been accepted downstream. The upstream stage flags the last codeword of a packet and pads the stream to whole blocks.

Top module: `chirp_interleaver`

## Requirements
- R1: After reset the block is idle: `out_valid`, `out_last` and `in_ready` are all 0.
- R2: A payload block accepts `sf` codewords and uses only bits `[cr+3:0]` of each; higher codeword bits have no effect. It then emits `cr+4` symbols, each below `2**sf`.
- R3: When the header flag is set, the first block of the packet accepts `sf-2` codewords and uses all 8 bits of each, whatever `cr` is. It then emits 8 symbols. Every later block of the packet is a payload block.
- R4: Output words leave in order `i = 0, 1, ...`. Before the Gray step, bit `j` of word `i` equals bit `i` of codeword `(i+j) mod rows`. Codewords are numbered 0 upward in arrival order within the block, and `rows` is the row count of the block.
- R5: Each symbol is the binary value whose Gray code is the interleaved word: symbol bit `k` is the XOR of word bits `k` and above.
- R6: Header symbols are the Gray-step result shifted left by two, so their two low bits are 0.
- R7: `cfg_sf`, `cfg_cr` and `cfg_hdr` are sampled in the first cycle `in_valid` is high while the block is idle. Changes to them during the packet have no effect on any symbol of that packet.
- R8: `out_last` is 1 only on the final symbol of the block that holds the codeword marked with `in_last`. After that symbol is accepted the block returns to idle.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sym` and `out_last` hold their values into the next cycle.
- R10: `in_ready` and `out_valid` are never 1 in the same cycle. A block fills completely, then drains completely.
- R11: With the header flag clear, every block of the packet is a payload block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sf | input | 4 | Spreading factor, 7 to 12 |
| cfg_cr | input | 3 | Coding rate parameter, 1 to 4 |
| cfg_hdr | input | 1 | Packet opens with a header block |
| in_valid | input | 1 | Codeword present |
| in_ready | output | 1 | Codeword accepted this cycle when valid |
| in_cw | input | 8 | Codeword, bit 0 first row-bit |
| in_last | input | 1 | Marks the final codeword of the packet |
| out_valid | output | 1 | Symbol present |
| out_ready | input | 1 | Downstream accepts the symbol |
| out_sym | output | 12 | Symbol number |
| out_last | output | 1 | Final symbol of the packet |

## Verification
The checker watches every cycle for four things: symbols held steady under backpressure, no overlap of the fill and drain phases, zero low bits on header symbols, and symbols kept within `sf` bits. It also checks that the captured configuration never moves while a packet is in flight, and that the block goes idle after the final symbol. The exact value of each symbol can only be shown by the bench's scenarios: the diagonal bit selection, the Gray inversion, the switch from the header geometry to the payload geometry, and the masking of unused codeword bits. The same holds for which symbol carries the end marker. The bench compares every symbol against its own model across several spreading factors, coding rates and header settings, scrambling the configuration inputs while each packet is in flight.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int MAX_SF   = 12;
    localparam int MIN_SF   = 7;
    localparam int CW_W     = 8;
    localparam int HDR_LOSS = 2;
    localparam int MAX_CR   = 4;
    localparam int CR_W     = 3;
    localparam int SF_W     = $clog2(MAX_SF + 1);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SF_W-1:0] sf;
        logic [CR_W-1:0] cr;
        logic            hdr;
    } pkt_cfg_t;

    // Inverse Gray: cascade an XOR from the top bit downwards.
    function automatic logic [MAX_SF-1:0] gray_undo(input logic [MAX_SF-1:0] g);
        logic [MAX_SF-1:0] b;
        logic acc;
        acc = 1'b0;
        for (int k = MAX_SF - 1; k >= 0; k--) begin
            acc  = acc ^ g[k];
            b[k] = acc;
        end
        return b;
    endfunction

    // Keep configuration inside the supported range.
    function automatic pkt_cfg_t cfg_sanitize(input logic [SF_W-1:0] sf,
                                              input logic [CR_W-1:0] cr,
                                              input logic hdr);
        pkt_cfg_t c;
        c.hdr = hdr;
        if (sf < SF_W'(MIN_SF))      c.sf = SF_W'(MIN_SF);
        else if (sf > SF_W'(MAX_SF)) c.sf = SF_W'(MAX_SF);
        else                         c.sf = sf;
        if (cr == '0)                c.cr = CR_W'(1);
        else if (cr > CR_W'(MAX_CR)) c.cr = CR_W'(MAX_CR);
        else                         c.cr = cr;
        return c;
    endfunction
endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int ROWS_MAX = MAX_SF,
    parameter int COLS_MAX = CW_W,
    localparam int RW = $clog2(ROWS_MAX + 1),
    localparam int CW = $clog2(COLS_MAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  pkt_cfg_t      cfg_in,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          wr_en,
    output logic [RW-1:0] wr_row,
    output logic [CW-1:0] rd_col,
    output logic [RW-1:0] rows,
    output logic          hdr_blk,
    output logic [RW-1:0] sf_cur,
    output logic          out_valid,
    output logic          out_last
);
    phase_e        phase_q;
    pkt_cfg_t      cfg_q;
    logic          hdr_q;
    logic [RW-1:0] cnt_q;
    logic [CW-1:0] col_q;
    logic          last_q;
    logic [RW-1:0] cols;
    logic          fill_end;
    logic          drain_end;

    always_comb begin
        rows      = hdr_q ? RW'(cfg_q.sf) - RW'(HDR_LOSS) : RW'(cfg_q.sf);
        cols      = hdr_q ? RW'(COLS_MAX) : RW'(cfg_q.cr) + RW'(4);
        in_ready  = (phase_q == PH_FILL);
        out_valid = (phase_q == PH_DRAIN);
        wr_en     = in_ready && in_valid;
        wr_row    = cnt_q;
        rd_col    = col_q;
        hdr_blk   = hdr_q;
        sf_cur    = RW'(cfg_q.sf);
        fill_end  = wr_en && (cnt_q == rows - RW'(1));
        drain_end = (RW'(col_q) == cols - RW'(1));
        out_last  = out_valid && last_q && drain_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cfg_q   <= cfg_sanitize(SF_W'(MIN_SF), CR_W'(1), 1'b0);
            hdr_q   <= 1'b0;
            cnt_q   <= '0;
            col_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (in_valid) begin
                        cfg_q   <= cfg_in;
                        hdr_q   <= cfg_in.hdr;
                        cnt_q   <= '0;
                        col_q   <= '0;
                        last_q  <= 1'b0;
                        phase_q <= PH_FILL;
                    end
                end
                PH_FILL: begin
                    if (wr_en) begin
                        if (in_last) last_q <= 1'b1;
                        if (fill_end) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DRAIN;
                        end else begin
                            cnt_q <= cnt_q + RW'(1);
                        end
                    end
                end
                PH_DRAIN: begin
                    if (out_ready) begin
                        if (drain_end) begin
                            col_q   <= '0;
                            hdr_q   <= 1'b0;
                            phase_q <= last_q ? PH_IDLE : PH_FILL;
                        end else begin
                            col_q <= col_q + CW'(1);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ilv_store.sv
module ilv_store
    import ilv_pkg::*;
#(
    parameter int ROWS_MAX = MAX_SF,
    parameter int COLS_MAX = CW_W,
    localparam int RW = $clog2(ROWS_MAX + 1)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [RW-1:0]                      wr_row,
    input  logic [COLS_MAX-1:0]                wr_cw,
    output logic [ROWS_MAX-1:0][COLS_MAX-1:0]  mem
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[wr_row] <= wr_cw;
        end
    end
endmodule

// File: rtl/ilv_shuffle.sv
module ilv_shuffle
    import ilv_pkg::*;
#(
    parameter int ROWS_MAX = MAX_SF,
    parameter int COLS_MAX = CW_W,
    localparam int RW = $clog2(ROWS_MAX + 1),
    localparam int CW = $clog2(COLS_MAX),
    localparam int SW = $clog2(ROWS_MAX + COLS_MAX)
) (
    input  logic [ROWS_MAX-1:0][COLS_MAX-1:0] mem,
    input  logic [CW-1:0]                     col,
    input  logic [RW-1:0]                     rows,
    input  logic                              hdr,
    output logic [ROWS_MAX-1:0]               sym
);
    logic [ROWS_MAX-1:0] word;
    logic [ROWS_MAX-1:0] bin;

    for (genvar j = 0; j < ROWS_MAX; j++) begin : g_row
        logic [SW-1:0] s0, s1, s2, s3;
        always_comb begin
            // (col + j) mod rows; the sum never exceeds four times rows
            s0 = SW'(col) + SW'(j);
            s1 = (s0 >= SW'(rows)) ? s0 - SW'(rows) : s0;
            s2 = (s1 >= SW'(rows)) ? s1 - SW'(rows) : s1;
            s3 = (s2 >= SW'(rows)) ? s2 - SW'(rows) : s2;
            if (RW'(j) < rows) word[j] = mem[RW'(s3)][col];
            else               word[j] = 1'b0;
        end
    end

    always_comb begin
        bin = gray_undo(word);
        sym = hdr ? (bin << HDR_LOSS) : bin;
    end
endmodule

// File: rtl/chirp_interleaver.sv
module chirp_interleaver
    import ilv_pkg::*;
#(
    parameter int ROWS_MAX = MAX_SF,
    parameter int COLS_MAX = CW_W,
    localparam int RW = $clog2(ROWS_MAX + 1),
    localparam int CW = $clog2(COLS_MAX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SF_W-1:0]     cfg_sf,
    input  logic [CR_W-1:0]     cfg_cr,
    input  logic                cfg_hdr,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [COLS_MAX-1:0] in_cw,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ROWS_MAX-1:0] out_sym,
    output logic                out_last
);
    pkt_cfg_t                          cfg_in;
    logic                              wr_en;
    logic [RW-1:0]                     wr_row;
    logic [CW-1:0]                     rd_col;
    logic [RW-1:0]                     rows;
    logic                              hdr_blk;
    logic [RW-1:0]                     sf_q;
    logic [ROWS_MAX-1:0][COLS_MAX-1:0] mem;

    assign cfg_in = cfg_sanitize(cfg_sf, cfg_cr, cfg_hdr);

    ilv_ctrl #(.ROWS_MAX(ROWS_MAX), .COLS_MAX(COLS_MAX)) u_ctrl (
        .clk(clk), .rst(rst), .cfg_in(cfg_in),
        .in_valid(in_valid), .in_last(in_last), .out_ready(out_ready),
        .in_ready(in_ready), .wr_en(wr_en), .wr_row(wr_row), .rd_col(rd_col),
        .rows(rows), .hdr_blk(hdr_blk), .sf_cur(sf_q),
        .out_valid(out_valid), .out_last(out_last)
    );

    ilv_store #(.ROWS_MAX(ROWS_MAX), .COLS_MAX(COLS_MAX)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row),
        .wr_cw(in_cw), .mem(mem)
    );

    ilv_shuffle #(.ROWS_MAX(ROWS_MAX), .COLS_MAX(COLS_MAX)) u_shuffle (
        .mem(mem), .col(rd_col), .rows(rows), .hdr(hdr_blk), .sym(out_sym)
    );
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
    parameter int ROWS_MAX = 12,
    localparam int RW = $clog2(ROWS_MAX + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [ROWS_MAX-1:0] out_sym,
    input logic                out_last,
    input logic                hdr_blk,
    input logic [RW-1:0]       sf_q
);
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(out_last));

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    a_r6_hdr_low_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid && hdr_blk |-> out_sym[1:0] == 2'b00);

    a_r2_sym_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sym >> sf_q) == '0);

    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        in_ready || out_valid |=> $stable(sf_q));

    a_r8_last_exit: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !out_valid && !in_ready);
endmodule

bind chirp_interleaver ilv_checker #(.ROWS_MAX(ROWS_MAX)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_sym(out_sym), .out_last(out_last),
    .hdr_blk(hdr_blk), .sf_q(sf_q)
);

// File: tb/chirp_interleaver_bench.sv
module chirp_interleaver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {sf[3:0], cr[2:0], hdr, blocks[3:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {4'd7,  3'd1, 1'b1, 4'd2},
        {4'd8,  3'd4, 1'b1, 4'd2},
        {4'd12, 3'd4, 1'b1, 4'd1},
        {4'd12, 3'd1, 1'b0, 4'd2},
        {4'd9,  3'd2, 1'b1, 4'd3},
        {4'd10, 3'd3, 1'b0, 4'd1},
        {4'd11, 3'd4, 1'b1, 4'd2},
        {4'd7,  3'd4, 1'b0, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_sf = 4'd7;
    logic [2:0]  cfg_cr = 3'd1;
    logic        cfg_hdr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_cw = 8'd0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [11:0] out_sym;
    logic        out_last;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0]  cws [64];
    logic [11:0] exp_sym [128];
    bit          exp_hdr [128];
    int          ncw, nsym;

    always #(CLK_PERIOD/2) clk = ~clk;

    chirp_interleaver u_chirp_interleaver (
        .clk(clk), .rst(rst), .cfg_sf(cfg_sf), .cfg_cr(cfg_cr), .cfg_hdr(cfg_hdr),
        .in_valid(in_valid), .in_ready(in_ready), .in_cw(in_cw), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym), .out_last(out_last)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [11:0] ungray(input logic [11:0] w);
        logic [11:0] b;
        for (int k = 0; k < 12; k++) b[k] = ^(w >> k);
        return b;
    endfunction

    // Build codewords and expected symbols for one packet.
    task automatic plan_pkt(input int sf, input int cr, input bit hdr, input int nblk, input int seed);
        int base;
        ncw = 0; nsym = 0; base = 0;
        for (int b = 0; b < nblk + (hdr ? 1 : 0); b++) begin
            bit h;
            int r, c;
            h = hdr && (b == 0);
            r = h ? sf - 2 : sf;
            c = h ? 8 : cr + 4;
            for (int k = 0; k < r; k++) begin
                cws[ncw] = 8'((ncw * 73 + seed * 29 + 17) ^ (ncw << 3));
                ncw++;
            end
            for (int i = 0; i < c; i++) begin
                logic [11:0] w;
                w = '0;
                for (int j = 0; j < r; j++) w[j] = cws[base + ((i + j) % r)][i];
                exp_sym[nsym] = h ? (ungray(w) << 2) : ungray(w);
                exp_hdr[nsym] = h;
                nsym++;
            end
            base += r;
        end
    endtask

    task automatic run_pkt(input int sf, input int cr, input bit hdr, input int nblk,
                           input int seed, input int pat);
        plan_pkt(sf, cr, hdr, nblk, seed);
        @(negedge clk);
        cfg_sf = 4'(sf); cfg_cr = 3'(cr); cfg_hdr = hdr;
        fork
            begin : drv
                int k;
                k = 0;
                while (k < ncw) begin
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_cw    = cws[k];
                    in_last  = (k == ncw - 1);
                    if (in_ready) begin
                        k++;
                        // scramble config once captured (R7)
                        cfg_sf  = 4'(7 + ((k + seed) % 6));
                        cfg_cr  = 3'(1 + (k % 4));
                        cfg_hdr = ~hdr;
                    end
                end
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            begin : rcv
                int idx, cyc;
                bit pend, overlap;
                logic [11:0] held;
                logic held_last;
                idx = 0; cyc = 0; pend = 0; overlap = 0;
                held = '0; held_last = 1'b0;
                while (idx < nsym) begin
                    @(negedge clk);
                    cyc++;
                    if (in_ready && out_valid) overlap = 1;
                    if (pat == 0)      out_ready = 1'b1;
                    else if (pat == 1) out_ready = ((cyc * 7 + seed) % 5) != 0;
                    else               out_ready = (cyc % 8) >= 6;
                    if (out_valid) begin
                        if (pend)
                            check(out_sym == held && out_last == held_last, "R9 stall hold",
                                  int'(out_sym), int'(held));
                        if (out_ready) begin
                            string tag;
                            if (exp_hdr[idx]) tag = "R3 R4 R5 R6 R7 header symbol";
                            else if (hdr)     tag = "R2 R4 R5 R7 payload symbol";
                            else              tag = "R2 R4 R5 R7 R11 payload symbol";
                            check(out_sym == exp_sym[idx], tag, int'(out_sym), int'(exp_sym[idx]));
                            check(out_last == (idx == nsym - 1), "R8 end marker",
                                  int'(out_last), int'(idx == nsym - 1));
                            idx++;
                            pend = 0;
                        end else begin
                            pend = 1;
                            held = out_sym;
                            held_last = out_last;
                        end
                    end
                end
                @(negedge clk);
                out_ready = 1'b0;
                check(!out_valid && !in_ready, "R8 idle after packet",
                      int'({out_valid, in_ready}), 0);
                check(!overlap, "R10 fill/drain overlap", int'(overlap), 0);
            end
        join
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!out_valid && !in_ready && !out_last, "R1 reset idle",
              int'({out_valid, in_ready, out_last}), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_pkt(int'(VEC[v][11:8]), int'(VEC[v][7:5]), VEC[v][4], int'(VEC[v][3:0]), v, 1);
        end

        // Full-rate downstream and long stalls
        run_pkt(10, 2, 1'b1, 2, 20, 0);
        run_pkt(8, 3, 1'b0, 1, 21, 2);
        run_pkt(12, 2, 1'b1, 2, 22, 2);
        // R3: header block ignores cr
        run_pkt(9, 1, 1'b1, 1, 23, 0);

        // R1: reset in the middle of a fill returns to idle
        @(negedge clk);
        cfg_sf = 4'd9; cfg_cr = 3'd2; cfg_hdr = 1'b0;
        in_valid = 1'b1; in_cw = 8'h5a; in_last = 1'b0;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!out_valid && !in_ready && !out_last, "R1 reset mid-packet",
              int'({out_valid, in_ready, out_last}), 0);
        run_pkt(7, 2, 1'b1, 1, 24, 1);

        finish_run();
    end
endmodule